// File: doc/BRIEF.md
# Timestamped Event Cluster Packer

The packer sits between a logic-capture front end and sample memory. It takes the probe word present on `sample_in` each clock and builds one 16-bit event per event period. In the one-sample mode a rate divider sets that period. In the two- and four-sample modes, fewer channels are captured several times per event and their bits are interleaved into the event word. Events are gathered into fixed clusters of eight 16-bit words: a timestamp followed by seven events.

A new cluster opens only when the incoming event differs from the last stored one. A new cluster is also forced when the distance to the previous cluster's timestamp reaches a limit. Otherwise the event is dropped and only the timestamp moves on. A reader that sees a timestamp gap wider than seven events therefore fills the missing events with the last stored event. Finished clusters leave as bursts of eight words, each with a write strobe and a word address. A separate counter reports how many events have been stored so far, which serves as the stop position.

The block assumes that `mode` and `frac` stay constant while `enable` is high. A cluster is always at least 14 clocks apart from the next one, so a burst always drains before the next cluster completes.

Top module: `evclus_packer`

## Requirements
- R1: After a clock edge with `rst_n` low, `wr_valid` is 0, `wr_addr` is 0 and `stop_pos` is 0, and the timestamp counter restarts at 0.
- R2: While `enable` is low, no event is formed, the timestamp does not advance, `stop_pos` holds and no word is written.
- R3: With `mode` 00 (one sample per event), the event period is 2×(`frac`+1) clocks, counted from the first clock with `enable` high. The event is `sample_in[15:0]` taken on the last clock of the period, so the first burst starts 14×(`frac`+1) clocks after `enable` rises.
- R4: With `mode` 01 (two samples of 8 channels), the event period is 2 clocks. `sample_in[7:0]` on the first clock is sample 0 and on the second clock is sample 1. Channel l of sample k lands on event bit 2l+k. `sample_in[15:8]` is ignored.
- R5: With `mode` 10 or 11 (four samples of 4 channels), the event period is 2 clocks. Samples 0 and 1 are `sample_in[3:0]` and `sample_in[7:4]` on the first clock. Samples 2 and 3 are the same fields on the second clock. Channel l of sample k lands on event bit 4l+k. `sample_in[15:8]` is ignored.
- R6: The 16-bit timestamp counts every formed event since reset, starting at 0. A cluster's first word is the timestamp of its first event.
- R7: Outside an open cluster, an event opens a new cluster if it is the first event since reset or if it differs from the last stored event. An event equal to the last stored event is not stored.
- R8: An event that equals the last stored event still opens a cluster once its timestamp minus the previous cluster's timestamp (modulo 2^16) is at least `FORCE_GAP`.
- R9: An open cluster stores the next six events unconditionally. The cluster is then written as eight words: the timestamp, then the seven events oldest first. The words go out on eight consecutive clocks with `wr_valid` high, starting the clock after the seventh event. An unfinished cluster is never written.
- R10: `wr_addr` starts at 0 and advances by one after each written word.
- R11: `stop_pos` is the number of stored events since reset and changes by at most one per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Capture run; low freezes event formation |
| mode | input | 2 | 00 one sample, 01 two samples, 1x four samples per event |
| frac | input | FRAC_W | Divider setting for the one-sample mode |
| sample_in | input | EV_W | Probe word from the front end |
| wr_valid | output | 1 | Word strobe toward sample memory |
| wr_data | output | EV_W | Cluster word |
| wr_addr | output | ADDR_W | Word address of `wr_data` |
| stop_pos | output | POS_W | Count of stored events |

## Verification
The hardest situation to reach is a forced cluster on an unchanging input. It normally needs tens of thousands of identical events. The bench therefore builds the block with a small gap limit and holds one constant probe value for well over twice that many events, so that several forced clusters appear. Idle stretches between clusters are produced by input patterns that hold a value for ten events. These make the timestamp gaps visible in the written words. Every written word is compared with clusters rebuilt in the bench from the requested samples.

// File: rtl/evclus_pkg.sv
// Shared constants for the event cluster packer: cluster geometry and
// the rate-mode encoding. Assumes 16-bit event and timestamp words.
package evclus_pkg;
    localparam int CL_EVENTS = 7;
    localparam int CL_WORDS  = CL_EVENTS + 1;

    typedef logic [1:0] rate_mode_t;
    localparam rate_mode_t RM_ONE = 2'b00;
    localparam rate_mode_t RM_TWO = 2'b01;
endpackage

// File: rtl/evclus_tick.sv
// Event period generator. Marks the last clock of each event period and
// keeps the sample slot seen on the clock before it. Period is
// 2*(frac+1) clocks in the one-sample mode, 2 clocks otherwise.
// Assumes mode and frac are static while enable is high.
module evclus_tick
    import evclus_pkg::*;
#(
    parameter int FRAC_W = 8,
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [1:0]        mode,
    input  logic [FRAC_W-1:0] frac,
    input  logic [HOLD_W-1:0] slot_in,
    output logic              tick,
    output logic [HOLD_W-1:0] held
);
    localparam int CNT_W = FRAC_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last_cnt;

    // terminal count of the period for the selected mode
    always_comb begin
        if (mode == RM_ONE) last_cnt = {frac, 1'b1};
        else                last_cnt = CNT_W'(1);
    end

    assign tick = enable && (cnt == last_cnt);

    // period counter, cleared whenever capture is stopped
    always_ff @(posedge clk) begin
        if (!rst_n)                         cnt <= '0;
        else if (!enable || cnt >= last_cnt) cnt <= '0;
        else                                cnt <= cnt + 1'b1;
    end

    // keep the slot from the second-to-last clock of the period
    always_ff @(posedge clk) begin
        if (!rst_n)                                        held <= '0;
        else if (enable && cnt == (last_cnt - CNT_W'(1)))  held <= slot_in;
    end
endmodule

// File: rtl/evclus_weave.sv
// Event word builder. Interleaves time-consecutive narrow samples so that
// channel l of sample k sits at bit l*S+k, S being samples per event.
// Assumes EV_W is divisible by four. Purely combinational.
module evclus_weave
    import evclus_pkg::*;
#(
    parameter int EV_W = 16
) (
    input  logic [1:0]        mode,
    input  logic [EV_W/2-1:0] held,
    input  logic [EV_W-1:0]   cur,
    output logic [EV_W-1:0]   ev
);
    localparam int HALF_W = EV_W / 2;
    localparam int QTR_W  = EV_W / 4;

    logic [EV_W-1:0] ev_x2;
    logic [EV_W-1:0] ev_x4;

    genvar l2;
    generate
        for (l2 = 0; l2 < HALF_W; l2++) begin : g_x2
            assign ev_x2[2*l2]   = held[l2];
            assign ev_x2[2*l2+1] = cur[l2];
        end
    endgenerate

    genvar l4;
    generate
        for (l4 = 0; l4 < QTR_W; l4++) begin : g_x4
            assign ev_x4[4*l4]   = held[l4];
            assign ev_x4[4*l4+1] = held[QTR_W+l4];
            assign ev_x4[4*l4+2] = cur[l4];
            assign ev_x4[4*l4+3] = cur[QTR_W+l4];
        end
    endgenerate

    // pick the layout for the active mode
    always_comb begin
        case (mode)
            RM_ONE:  ev = cur;
            RM_TWO:  ev = ev_x2;
            default: ev = ev_x4;
        endcase
    end
endmodule

// File: rtl/evclus_asm.sv
// Cluster assembler. Keeps the event timestamp, decides when a cluster
// opens (first event, changed event, or timestamp distance limit), fills
// seven events and presents the finished cluster for one clock on done.
// Assumes tick is a single-clock strobe at most every second clock.
module evclus_asm
    import evclus_pkg::*;
#(
    parameter int EV_W      = 16,
    parameter int POS_W     = 24,
    parameter int FORCE_GAP = 65520
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [EV_W-1:0]   ev,
    output logic              done,
    output logic [EV_W-1:0]   cl_words [CL_WORDS],
    output logic [POS_W-1:0]  stop_pos
);
    localparam int IDX_W = $clog2(CL_EVENTS);
    localparam logic [EV_W-1:0]  GAP_LIM  = EV_W'(FORCE_GAP);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CL_EVENTS - 1);

    logic [EV_W-1:0]  ts_cnt;
    logic [EV_W-1:0]  cl_ts;
    logic [EV_W-1:0]  ref_ts;
    logic [EV_W-1:0]  last_ev;
    logic             have_last;
    logic             filling;
    logic [IDX_W-1:0] fill_idx;
    logic [EV_W-1:0]  ev_buf [CL_EVENTS-1];
    logic [EV_W-1:0]  gap;
    logic             start;
    logic             store;

    // open/store decisions for the event on this clock
    always_comb begin
        gap   = ts_cnt - ref_ts;
        start = !filling && (!have_last || (ev != last_ev) || (gap >= GAP_LIM));
        store = filling || start;
        done  = tick && filling && (fill_idx == IDX_LAST);
    end

    // timestamp, position and fill state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_cnt    <= '0;
            cl_ts     <= '0;
            ref_ts    <= '0;
            last_ev   <= '0;
            have_last <= 1'b0;
            filling   <= 1'b0;
            fill_idx  <= '0;
            stop_pos  <= '0;
        end else if (tick) begin
            ts_cnt <= ts_cnt + 1'b1;
            if (store) begin
                last_ev   <= ev;
                have_last <= 1'b1;
                stop_pos  <= stop_pos + 1'b1;
            end
            if (start) begin
                filling  <= 1'b1;
                fill_idx <= IDX_W'(1);
                cl_ts    <= ts_cnt;
                ref_ts   <= ts_cnt;
            end else if (filling) begin
                if (fill_idx == IDX_LAST) begin
                    filling  <= 1'b0;
                    fill_idx <= '0;
                end else begin
                    fill_idx <= fill_idx + 1'b1;
                end
            end
        end
    end

    // event storage for all but the closing event of a cluster
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CL_EVENTS - 1; i++) ev_buf[i] <= '0;
        end else if (tick && start) begin
            ev_buf[0] <= ev;
        end else if (tick && filling && !done) begin
            ev_buf[fill_idx] <= ev;
        end
    end

    // finished cluster image: timestamp, stored events, closing event
    always_comb begin
        cl_words[0] = cl_ts;
        for (int i = 0; i < CL_EVENTS - 1; i++) cl_words[i+1] = ev_buf[i];
        cl_words[CL_WORDS-1] = ev;
    end
endmodule

// File: rtl/evclus_emit.sv
// Word emitter. Latches a finished cluster and writes it out over eight
// consecutive clocks with a running word address. Assumes a new load
// never arrives while a burst is still in flight.
module evclus_emit
    import evclus_pkg::*;
#(
    parameter int EV_W   = 16,
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [EV_W-1:0]   words [CL_WORDS],
    output logic              wr_valid,
    output logic [EV_W-1:0]   wr_data,
    output logic [ADDR_W-1:0] wr_addr
);
    localparam int SEL_W = $clog2(CL_WORDS);
    localparam logic [SEL_W-1:0] SEL_LAST = SEL_W'(CL_WORDS - 1);

    logic [EV_W-1:0]   hold [CL_WORDS];
    logic [SEL_W-1:0]  sel;
    logic              busy;
    logic [ADDR_W-1:0] addr;

    // capture the cluster image
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < CL_WORDS; i++) hold[i] <= '0;
        end else if (load) begin
            hold <= words;
        end
    end

    // burst sequencing and address advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            sel  <= '0;
            addr <= '0;
        end else if (load) begin
            busy <= 1'b1;
            sel  <= '0;
        end else if (busy) begin
            addr <= addr + 1'b1;
            if (sel == SEL_LAST) busy <= 1'b0;
            else                 sel  <= sel + 1'b1;
        end
    end

    assign wr_valid = busy;
    assign wr_data  = hold[sel];
    assign wr_addr  = addr;
endmodule

// File: rtl/evclus_packer.sv
// Top of the event cluster packer: period generator, event builder,
// cluster assembler and word emitter in a chain. Assumes mode and frac
// are held while enable is high.
module evclus_packer
    import evclus_pkg::*;
#(
    parameter int EV_W      = 16,
    parameter int FRAC_W    = 8,
    parameter int POS_W     = 24,
    parameter int ADDR_W    = 24,
    parameter int FORCE_GAP = 65520
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [1:0]        mode,
    input  logic [FRAC_W-1:0] frac,
    input  logic [EV_W-1:0]   sample_in,
    output logic              wr_valid,
    output logic [EV_W-1:0]   wr_data,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [POS_W-1:0]  stop_pos
);
    localparam int HALF_W = EV_W / 2;

    logic              tick;
    logic [HALF_W-1:0] held;
    logic [EV_W-1:0]   ev;
    logic              done;
    logic [EV_W-1:0]   cl_words [CL_WORDS];

    evclus_tick #(.FRAC_W(FRAC_W), .HOLD_W(HALF_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .mode    (mode),
        .frac    (frac),
        .slot_in (sample_in[HALF_W-1:0]),
        .tick    (tick),
        .held    (held)
    );

    evclus_weave #(.EV_W(EV_W)) u_weave (
        .mode (mode),
        .held (held),
        .cur  (sample_in),
        .ev   (ev)
    );

    evclus_asm #(.EV_W(EV_W), .POS_W(POS_W), .FORCE_GAP(FORCE_GAP)) u_asm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .ev       (ev),
        .done     (done),
        .cl_words (cl_words),
        .stop_pos (stop_pos)
    );

    evclus_emit #(.EV_W(EV_W), .ADDR_W(ADDR_W)) u_emit (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (done),
        .words    (cl_words),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .wr_addr  (wr_addr)
    );
endmodule

// File: rtl/evclus_packer_chk.sv
// Port-level checker for the event cluster packer, bound to every
// instance of the top module.
module evclus_packer_chk #(
    parameter int ADDR_W = 24,
    parameter int POS_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [POS_W-1:0]  stop_pos
);
    logic       in_rst_q;
    logic [3:0] run_len;

    // remembers that the previous edge was a reset edge
    always_ff @(posedge clk) in_rst_q <= !rst_n;

    // length of the current write burst so far
    always_ff @(posedge clk) begin
        if (!rst_n)        run_len <= '0;
        else if (wr_valid) run_len <= run_len + 1'b1;
        else               run_len <= '0;
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_rst_q |-> (!wr_valid && wr_addr == '0 && stop_pos == '0));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(stop_pos));

    // R9
    burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (run_len < 4'd8));

    // R9
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_valid) |-> (run_len == 4'd8));

    // R10
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> (wr_addr == $past(wr_addr) + ADDR_W'(1)));

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> $stable(wr_addr));

    // R11
    pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_pos - $past(stop_pos)) <= POS_W'(1));
endmodule

bind evclus_packer evclus_packer_chk #(.ADDR_W(ADDR_W), .POS_W(POS_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .stop_pos (stop_pos)
);

// File: tb/evclus_packer_tb.sv
`timescale 1ns/1ps
module evclus_packer_tb;
    localparam int GAP = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [7:0]  frac = 8'd0;
    logic [15:0] sample_in = 16'd0;
    logic        wr_valid;
    logic [15:0] wr_data;
    logic [23:0] wr_addr;
    logic [23:0] stop_pos;

    evclus_packer #(.FORCE_GAP(GAP)) u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .frac(frac),
        .sample_in(sample_in), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_addr(wr_addr), .stop_pos(stop_pos)
    );

    always #10 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done_flag = 0;
    logic [15:0] cap_d [0:255];
    logic [23:0] cap_a [0:255];
    int cap_n = 0;
    logic [15:0] exp_d [0:255];
    int exp_n;
    int exp_st;

    // stimulus table: mode, frac, pattern, events, expected clusters
    localparam logic [31:0] ROWS [8] = '{
        {2'd0, 8'd0, 2'd0, 12'd21,  8'd3},
        {2'd0, 8'd2, 2'd2, 12'd30,  8'd3},
        {2'd1, 8'd0, 2'd0, 12'd14,  8'd2},
        {2'd1, 8'd0, 2'd1, 12'd21,  8'd1},
        {2'd2, 8'd0, 2'd0, 12'd28,  8'd4},
        {2'd3, 8'd0, 2'd2, 12'd30,  8'd3},
        {2'd0, 8'd0, 2'd1, 12'd100, 8'd3},
        {2'd0, 8'd1, 2'd0, 12'd10,  8'd1}
    };

    // collect written words
    always @(negedge clk) begin
        if (wr_valid) begin
            if (cap_n < 256) begin
                cap_d[cap_n] = wr_data;
                cap_a[cap_n] = wr_addr;
            end
            cap_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic int spe(input int m);
        return (m == 0) ? 1 : (m == 1) ? 2 : 4;
    endfunction

    function automatic logic [15:0] samp(input int pat, input int e, input int k, input int s);
        int v;
        case (pat)
            0:       v = (e * s + k) * 'h125 + 'h13;
            1:       v = 'hBEEF;
            default: v = (e / 10) * 'h125 + 'h13;
        endcase
        v = v & ((1 << (16 / s)) - 1);
        return v[15:0];
    endfunction

    function automatic logic [15:0] exp_ev(input int pat, input int e, input int m);
        int s = spe(m);
        logic [15:0] r = '0;
        logic [15:0] t;
        for (int k = 0; k < s; k++) begin
            t = samp(pat, e, k, s);
            for (int l = 0; l < 16 / s; l++) r[l*s+k] = t[l];
        end
        return r;
    endfunction

    function automatic logic [15:0] drive_val(input int pat, input int m, input int fr, input int c);
        logic [15:0] a;
        logic [15:0] b;
        if (m == 0) return samp(pat, c / (2 * (fr + 1)), 0, 1);
        if (m == 1) begin
            a = samp(pat, c / 2, c % 2, 2);
            return {8'hA5, a[7:0]};
        end
        a = samp(pat, c / 2, 2 * (c % 2), 4);
        b = samp(pat, c / 2, 2 * (c % 2) + 1, 4);
        return {8'h5A, b[3:0], a[3:0]};
    endfunction

    // reference clusters built from the requirements
    task automatic build_model(input int m, input int pat, input int n);
        logic [15:0] tmp [7];
        logic [15:0] last = '0;
        logic [15:0] ev;
        bit have = 0;
        bit fill = 0;
        int cnt = 0;
        int cts = 0;
        int refts = 0;
        exp_n = 0;
        exp_st = 0;
        for (int e = 0; e < n; e++) begin
            ev = exp_ev(pat, e, m);
            if (!fill) begin
                if (!have || ev != last || (e - refts) >= GAP) begin
                    fill = 1; cnt = 1; cts = e; refts = e; tmp[0] = ev;
                    exp_st++; last = ev; have = 1;
                end
            end else begin
                tmp[cnt] = ev; cnt++; exp_st++; last = ev;
                if (cnt == 7) begin
                    exp_d[exp_n] = 16'(cts); exp_n++;
                    for (int i = 0; i < 7; i++) begin
                        exp_d[exp_n] = tmp[i]; exp_n++;
                    end
                    fill = 0;
                end
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        enable = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cap_n = 0;
    endtask

    task automatic run_row(input int m, input int fr, input int pat, input int n,
                           input int ncl, input int idle);
        int p;
        string tg;
        do_reset();
        mode = m[1:0];
        frac = fr[7:0];
        for (int i = 0; i < idle; i++) begin
            sample_in = 16'(i * 'h3131);
            @(negedge clk);
        end
        if (idle > 0) begin
            chk(cap_n == 0, "R2", "writes while idle", cap_n, 0);
            chk(stop_pos == 0, "R2", "stop_pos while idle", stop_pos, 0);
        end
        p = (m == 0) ? 2 * (fr + 1) : 2;
        for (int c = 0; c < n * p; c++) begin
            enable = 1'b1;
            sample_in = drive_val(pat, m, fr, c);
            @(negedge clk);
        end
        enable = 1'b0;
        repeat (20) @(negedge clk);
        build_model(m, pat, n);
        tg = (pat == 1 && n > 50) ? "R8" : "R7";
        chk(cap_n / 8 == ncl, tg, "cluster count", cap_n / 8, ncl);
        chk(cap_n == exp_n, "R9", "word count", cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++) begin
            if (i % 8 == 0) tg = "R6";
            else if (m == 0) tg = "R3";
            else if (m == 1) tg = "R4";
            else tg = "R5";
            chk(cap_d[i] == exp_d[i], tg, "word data", cap_d[i], exp_d[i]);
            chk(cap_a[i] == 24'(i), "R10", "word address", cap_a[i], i);
        end
        chk(stop_pos == 24'(exp_st), "R11", "stored events", stop_pos, exp_st);
    endtask

    // cycles from enable to first written word
    task automatic lat_check(input int m, input int fr, input int expc, input string tg);
        int k = 0;
        do_reset();
        mode = m[1:0];
        frac = fr[7:0];
        enable = 1'b1;
        sample_in = drive_val(0, m, fr, 0);
        while (k < 20000) begin
            @(negedge clk);
            k++;
            if (wr_valid) break;
            sample_in = drive_val(0, m, fr, k);
        end
        enable = 1'b0;
        chk(k == expc, tg, "first write latency", k, expc);
        repeat (12) @(negedge clk);
    endtask

    initial begin
        logic [31:0] row;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        for (int r = 0; r < 8; r++) begin
            row = ROWS[r];
            run_row(int'(row[31:30]), int'(row[29:22]), int'(row[21:20]),
                    int'(row[19:8]), int'(row[7:0]), 0);
        end
        // R1: reset after a run clears outputs
        do_reset();
        @(negedge clk);
        chk(wr_valid == 1'b0, "R1", "wr_valid after reset", wr_valid, 0);
        chk(wr_addr == 24'd0, "R1", "wr_addr after reset", wr_addr, 0);
        chk(stop_pos == 24'd0, "R1", "stop_pos after reset", stop_pos, 0);
        // R2: idle stretch with moving input, then a capture from timestamp 0
        run_row(0, 0, 0, 7, 1, 40);
        // R3 divider settings, R4/R5 fixed periods
        lat_check(0, 0, 14, "R3");
        lat_check(0, 3, 56, "R3");
        lat_check(0, 255, 3584, "R3");
        lat_check(1, 0, 14, "R4");
        lat_check(2, 0, 14, "R5");
        if (!done_flag) begin
            done_flag = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule